// File: doc/BRIEF.md
# Dual-Pixel Video Timing Generator

The block is a programmable raster timing engine for a display output path. From horizontal and vertical settings (sync pulse width, back porch, active extent, front porch) plus a horizontal skew, it walks a pixel-clock raster and produces horizontal and vertical sync, a display-enable strobe and a data-valid strobe. It also exposes line and frame counters, and it runs a ready/valid pixel handshake toward an upstream source. Only a simple per-strobe invert is offered for polarity.

Two mode inputs shape the window arithmetic. The interface-kind input selects link-style adjustment: the display-enable window is pulled in so that it opens on the first active pixel and closes on the last one. The wide input selects the two-pixels-per-clock data path, which is a 64-bit bus holding two 32-bit pixels. On a link-style interface, wide mode halves every horizontal setting, so each line runs at half the clock count. On a generic interface, wide mode leaves the horizontal settings unchanged but shortens the data-valid window to half the active width. Settings are captured when the block is enabled and again at each frame boundary. When the source has no pixel while data is due, the block sends a fill colour and records an underflow.

Top module: `dpx_timing_gen`

## Requirements
- R1: A line lasts hsw+hbp+hact+hfp clocks and a frame lasts vsw+vbp+vact+vfp lines. line_cnt is the line index within the frame. frame_cnt increments by one after the last clock of each frame.
- R2: hsync is active for the first hsw clocks of each line and vsync is active for the first vsw lines of each frame. Active means 1 when the matching invert input is 0, and 0 when it is 1. While the block is disabled, both outputs sit at their inactive level.
- R3: Let the frame pixel index be line×htot+column. disp_en is 1 only when two conditions hold. First, the index lies between (vsw+vbp)×htot+skew and (vtot−vfp)×htot+skew−1 inclusive. Second, the column lies between hsw+hbp and htot−hfp−1 inclusive.
- R4: With dp_iface=1, the lower index bound of R3 is raised by hsw+hbp and the upper index bound is lowered by hfp.
- R5: With wide_mode=1 and dp_iface=1, hsw, hbp, hact and hfp are each shifted right by one before every timing computation. Skew and the vertical settings are not shifted.
- R6: data_valid equals disp_en restricted to columns below hsw+hbp+dw. dw is hact>>1 when wide_mode=1 and dp_iface=0, and otherwise dw is the (possibly halved) hact.
- R7: All settings are captured only on the clock that starts the block and on the last clock of each frame. Changes at other times have no effect until the next frame.
- R8: Raising enable restarts the raster: the first enabled clock shows column 0, line 0 and frame_cnt 0. Dropping enable clears the counters and idles all strobes.
- R9: px_ready equals data_valid. When data_valid and src_valid are both 1, px_data equals src_data. px_data is 0 whenever data_valid is 0.
- R10: When data_valid=1 and src_valid=0, px_data carries ufl_color in both 32-bit lanes. In that case underflow becomes 1 on the next clock and stays 1 until the next restart or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the raster; rising restarts it |
| wide_mode | input | 1 | Two pixels per clock |
| dp_iface | input | 1 | Link-style window adjustment |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync |
| h_sync_w | input | 12 | Horizontal sync width, pixels |
| h_back | input | 12 | Horizontal back porch, pixels |
| h_active | input | 12 | Active width, pixels |
| h_front | input | 12 | Horizontal front porch, pixels |
| v_sync_w | input | 12 | Vertical sync width, lines |
| v_back | input | 12 | Vertical back porch, lines |
| v_active | input | 12 | Active height, lines |
| v_front | input | 12 | Vertical front porch, lines |
| h_skew | input | 12 | Display window skew, clocks |
| ufl_color | input | 32 | Fill pixel sent on underflow |
| src_valid | input | 1 | Source has a pixel word |
| src_data | input | 64 | Source pixel word |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable window |
| data_valid | output | 1 | Pixel data window |
| px_ready | output | 1 | Pixel request to source |
| px_data | output | 64 | Pixel word out |
| underflow | output | 1 | Sticky underflow flag |
| line_cnt | output | 14 | Line index in frame |
| frame_cnt | output | 16 | Frames since restart |

## Verification
The raster is run through five patterns. A narrow generic setup with zero skew fixes the baseline window positions. A link-style setup with nonzero skew and both sync inverts separates the R4 index offsets from the R3 bounds. A wide link-style setup shows the halved line length, and a wide generic setup shows the full-length line with a half-width data window. A settings change made mid-frame must stay invisible until the frame boundary, which distinguishes boundary capture from immediate use. An intermittent and then absent source shows the fill colour, and the flag must stay set through later valid traffic and clear only on restart.

// File: rtl/dpx_tg_pkg.sv
package dpx_tg_pkg;

    localparam int unsigned HW    = 12;
    localparam int unsigned VW    = 12;
    localparam int unsigned HT_W  = HW + 2;
    localparam int unsigned VT_W  = VW + 2;
    localparam int unsigned IDX_W = HT_W + VT_W;

    typedef enum logic {IF_GENERIC = 1'b0, IF_LINK = 1'b1} if_kind_e;

    typedef struct packed {
        logic [HW-1:0] sw;
        logic [HW-1:0] bp;
        logic [HW-1:0] act;
        logic [HW-1:0] fp;
    } hparm_t;

    typedef struct packed {
        logic [VW-1:0] sw;
        logic [VW-1:0] bp;
        logic [VW-1:0] act;
        logic [VW-1:0] fp;
    } vparm_t;

    typedef struct packed {
        logic [HT_W-1:0]  htot;
        logic [HT_W-1:0]  hsw;
        logic [HT_W-1:0]  hstart;
        logic [HT_W-1:0]  hend;
        logic [HT_W-1:0]  dv_end;
        logic [VT_W-1:0]  vtot;
        logic [VT_W-1:0]  vsw;
        logic [IDX_W-1:0] dstart;
        logic [IDX_W-1:0] dend;
    } timing_t;

    function automatic logic [HT_W-1:0] hscale(logic [HW-1:0] v, logic halve);
        return halve ? HT_W'(v >> 1) : HT_W'(v);
    endfunction

    function automatic timing_t derive_timing(hparm_t hp, vparm_t vp,
                                              logic [HW-1:0] skew,
                                              logic wide, if_kind_e kind);
        timing_t          t;
        logic             halve;
        logic [HT_W-1:0]  sw, bp, act, fp, dw;
        logic [IDX_W-1:0] ht_x;
        halve    = wide && (kind == IF_LINK);
        sw       = hscale(hp.sw, halve);
        bp       = hscale(hp.bp, halve);
        act      = hscale(hp.act, halve);
        fp       = hscale(hp.fp, halve);
        t.htot   = sw + bp + act + fp;
        t.hsw    = sw;
        t.hstart = sw + bp;
        t.hend   = t.htot - fp - HT_W'(1);
        dw       = (wide && (kind == IF_GENERIC)) ? (act >> 1) : act;
        t.dv_end = t.hstart + dw;
        t.vtot   = VT_W'(vp.sw) + VT_W'(vp.bp) + VT_W'(vp.act) + VT_W'(vp.fp);
        t.vsw    = VT_W'(vp.sw);
        ht_x     = IDX_W'(t.htot);
        t.dstart = IDX_W'(VT_W'(vp.sw) + VT_W'(vp.bp)) * ht_x + IDX_W'(skew);
        t.dend   = IDX_W'(t.vtot - VT_W'(vp.fp)) * ht_x + IDX_W'(skew) - IDX_W'(1);
        if (kind == IF_LINK) begin
            t.dstart = t.dstart + IDX_W'(t.hstart);
            t.dend   = t.dend - IDX_W'(fp);
        end
        return t;
    endfunction

endpackage

// File: rtl/dpx_cfg_shadow.sv
module dpx_cfg_shadow
    import dpx_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  hparm_t        hp,
    input  vparm_t        vp,
    input  logic [HW-1:0] skew,
    input  logic          wide,
    input  if_kind_e      kind,
    output timing_t       tim
);

    always_ff @(posedge clk) begin
        if (rst)
            tim <= '0;
        else if (load)
            tim <= derive_timing(hp, vp, skew, wide, kind);
    end

    // Settings only move at a capture point
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tim));

endmodule

// File: rtl/dpx_raster_cnt.sv
module dpx_raster_cnt
    import dpx_tg_pkg::*;
#(
    parameter int unsigned FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [HT_W-1:0]    htot,
    input  logic [VT_W-1:0]    vtot,
    output logic               run,
    output logic [HT_W-1:0]    hcnt,
    output logic [VT_W-1:0]    vcnt,
    output logic [IDX_W-1:0]   idx,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               start,
    output logic               load
);

    logic line_end;
    logic frame_end;

    assign line_end  = run && (hcnt == htot - HT_W'(1));
    assign frame_end = line_end && (vcnt == vtot - VT_W'(1));
    assign start     = enable && !run;
    assign load      = start || (enable && frame_end);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run       <= 1'b0;
            hcnt      <= '0;
            vcnt      <= '0;
            idx       <= '0;
            frame_cnt <= '0;
        end else if (!run) begin
            run       <= 1'b1;
            hcnt      <= '0;
            vcnt      <= '0;
            idx       <= '0;
            frame_cnt <= '0;
        end else begin
            idx <= frame_end ? '0 : idx + IDX_W'(1);
            if (line_end) begin
                hcnt <= '0;
                if (frame_end) begin
                    vcnt      <= '0;
                    frame_cnt <= frame_cnt + FRAME_W'(1);
                end else begin
                    vcnt <= vcnt + VT_W'(1);
                end
            end else begin
                hcnt <= hcnt + HT_W'(1);
            end
        end
    end

    assert_hcnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (hcnt < htot) && (vcnt < vtot));

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && !run) |=> run && hcnt == '0 && vcnt == '0 && frame_cnt == '0);

endmodule

// File: rtl/dpx_strobe_gen.sv
module dpx_strobe_gen
    import dpx_tg_pkg::*;
(
    input  logic             run,
    input  logic [HT_W-1:0]  hcnt,
    input  logic [VT_W-1:0]  vcnt,
    input  logic [IDX_W-1:0] idx,
    input  logic [HT_W-1:0]  hsw,
    input  logic [HT_W-1:0]  hstart,
    input  logic [HT_W-1:0]  hend,
    input  logic [HT_W-1:0]  dv_end,
    input  logic [VT_W-1:0]  vsw,
    input  logic [IDX_W-1:0] dstart,
    input  logic [IDX_W-1:0] dend,
    input  logic             hs_inv,
    input  logic             vs_inv,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             dv
);

    logic in_idx;
    logic in_col;

    assign in_idx = (idx >= dstart) && (idx <= dend);
    assign in_col = (hcnt >= hstart) && (hcnt <= hend);

    always_comb begin
        hsync = (run && (hcnt < hsw)) ^ hs_inv;
        vsync = (run && (vcnt < vsw)) ^ vs_inv;
        de    = run && in_idx && in_col;
        dv    = de && (hcnt < dv_end);
    end

endmodule

// File: rtl/dpx_pixel_out.sv
module dpx_pixel_out #(
    parameter int unsigned PIX_W = 32,
    parameter int unsigned LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   dv,
    input  logic                   src_valid,
    input  logic [PIX_W*LANES-1:0] src_data,
    input  logic [PIX_W-1:0]       ufl_color,
    output logic                   px_ready,
    output logic [PIX_W*LANES-1:0] px_data,
    output logic                   underflow
);

    localparam int unsigned BUS_W = PIX_W * LANES;

    logic [BUS_W-1:0] fill;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign fill[l*PIX_W +: PIX_W] = ufl_color;
    end

    assign px_ready = dv;

    always_comb begin
        px_data = '0;
        if (dv)
            px_data = src_valid ? src_data : fill;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            underflow <= 1'b0;
        else if (dv && !src_valid)
            underflow <= 1'b1;
    end

    assert_uf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (underflow && !clear) |=> underflow);

    assert_uf_set_R10: assert property (@(posedge clk) disable iff (rst)
        (dv && !src_valid && !clear) |=> underflow);

endmodule

// File: rtl/dpx_timing_gen.sv
module dpx_timing_gen
    import dpx_tg_pkg::*;
#(
    parameter int unsigned PIX_W   = 32,
    parameter int unsigned LANES   = 2,
    parameter int unsigned FRAME_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   wide_mode,
    input  logic                   dp_iface,
    input  logic                   hs_inv,
    input  logic                   vs_inv,
    input  logic [HW-1:0]          h_sync_w,
    input  logic [HW-1:0]          h_back,
    input  logic [HW-1:0]          h_active,
    input  logic [HW-1:0]          h_front,
    input  logic [VW-1:0]          v_sync_w,
    input  logic [VW-1:0]          v_back,
    input  logic [VW-1:0]          v_active,
    input  logic [VW-1:0]          v_front,
    input  logic [HW-1:0]          h_skew,
    input  logic [PIX_W-1:0]       ufl_color,
    input  logic                   src_valid,
    input  logic [PIX_W*LANES-1:0] src_data,
    output logic                   hsync,
    output logic                   vsync,
    output logic                   disp_en,
    output logic                   data_valid,
    output logic                   px_ready,
    output logic [PIX_W*LANES-1:0] px_data,
    output logic                   underflow,
    output logic [VT_W-1:0]        line_cnt,
    output logic [FRAME_W-1:0]     frame_cnt
);

    hparm_t           hp;
    vparm_t           vp;
    timing_t          tim;
    if_kind_e         kind;
    logic             run, start, load;
    logic [HT_W-1:0]  hcnt;
    logic [IDX_W-1:0] idx;

    assign hp   = '{sw: h_sync_w, bp: h_back, act: h_active, fp: h_front};
    assign vp   = '{sw: v_sync_w, bp: v_back, act: v_active, fp: v_front};
    assign kind = dp_iface ? IF_LINK : IF_GENERIC;

    dpx_cfg_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .hp   (hp),
        .vp   (vp),
        .skew (h_skew),
        .wide (wide_mode),
        .kind (kind),
        .tim  (tim)
    );

    dpx_raster_cnt #(.FRAME_W(FRAME_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .htot      (tim.htot),
        .vtot      (tim.vtot),
        .run       (run),
        .hcnt      (hcnt),
        .vcnt      (line_cnt),
        .idx       (idx),
        .frame_cnt (frame_cnt),
        .start     (start),
        .load      (load)
    );

    dpx_strobe_gen u_strb (
        .run    (run),
        .hcnt   (hcnt),
        .vcnt   (line_cnt),
        .idx    (idx),
        .hsw    (tim.hsw),
        .hstart (tim.hstart),
        .hend   (tim.hend),
        .dv_end (tim.dv_end),
        .vsw    (tim.vsw),
        .dstart (tim.dstart),
        .dend   (tim.dend),
        .hs_inv (hs_inv),
        .vs_inv (vs_inv),
        .hsync  (hsync),
        .vsync  (vsync),
        .de     (disp_en),
        .dv     (data_valid)
    );

    dpx_pixel_out #(.PIX_W(PIX_W), .LANES(LANES)) u_pix (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .dv        (data_valid),
        .src_valid (src_valid),
        .src_data  (src_data),
        .ufl_color (ufl_color),
        .px_ready  (px_ready),
        .px_data   (px_data),
        .underflow (underflow)
    );

    assert_dv_inside_de_R6: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> disp_en);

    assert_idle_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !disp_en && !px_ready && px_data == '0);

    assert_ready_tracks_dv_R9: assert property (@(posedge clk) disable iff (rst)
        px_ready == data_valid);

endmodule

// File: tb/dpx_timing_gen_tb_top.sv
`timescale 1ns/1ps
module dpx_timing_gen_tb_top;
    import dpx_tg_pkg::*;

    typedef struct {
        logic rst, en, wide, dp, hinv, vinv;
        logic [11:0] hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, skew;
        logic [31:0] ucol;
        logic sv;
        logic [63:0] sd;
    } drv_t;

    typedef struct {
        logic hs, vs, de, dv, rdy, uf;
        logic [63:0] px;
        int line, frame;
        string ph;
    } exp_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    drv_t drv, cur;
    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int unsigned cyc = 0;
    int   sv_mode = 0;
    string phase = "R1/R2/R3";

    logic hsync, vsync, disp_en, data_valid, px_ready, underflow;
    logic [63:0] px_data;
    logic [VT_W-1:0] line_cnt;
    logic [15:0] frame_cnt;

    dpx_timing_gen dut_i (
        .clk(clk), .rst(cur.rst), .enable(cur.en), .wide_mode(cur.wide),
        .dp_iface(cur.dp), .hs_inv(cur.hinv), .vs_inv(cur.vinv),
        .h_sync_w(cur.hsw), .h_back(cur.hbp), .h_active(cur.hact), .h_front(cur.hfp),
        .v_sync_w(cur.vsw), .v_back(cur.vbp), .v_active(cur.vact), .v_front(cur.vfp),
        .h_skew(cur.skew), .ufl_color(cur.ucol), .src_valid(cur.sv), .src_data(cur.sd),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .data_valid(data_valid),
        .px_ready(px_ready), .px_data(px_data), .underflow(underflow),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt)
    );

    // reference raster state, built from the requirements
    bit m_run, m_uf;
    int m_h, m_v, m_f;
    int t_htot, t_hsw, t_hst, t_hend, t_dve, t_vtot, t_vsw, t_dst, t_dend;

    function automatic void derive_m();
        int sw, bp, act, fp, dw;
        bit halve;
        halve  = cur.wide && cur.dp;                    // R5
        sw     = halve ? int'(cur.hsw >> 1)  : int'(cur.hsw);
        bp     = halve ? int'(cur.hbp >> 1)  : int'(cur.hbp);
        act    = halve ? int'(cur.hact >> 1) : int'(cur.hact);
        fp     = halve ? int'(cur.hfp >> 1)  : int'(cur.hfp);
        t_htot = sw + bp + act + fp;                    // R1
        t_hsw  = sw;
        t_hst  = sw + bp;
        t_hend = t_htot - fp - 1;
        dw     = (cur.wide && !cur.dp) ? (act >> 1) : act; // R6
        t_dve  = t_hst + dw;
        t_vtot = int'(cur.vsw) + int'(cur.vbp) + int'(cur.vact) + int'(cur.vfp);
        t_vsw  = int'(cur.vsw);
        t_dst  = (int'(cur.vsw) + int'(cur.vbp)) * t_htot + int'(cur.skew);
        t_dend = (t_vtot - int'(cur.vfp)) * t_htot + int'(cur.skew) - 1;
        if (cur.dp) begin                               // R4
            t_dst  = t_dst + t_hst;
            t_dend = t_dend - fp;
        end
    endfunction

    function automatic exp_t calc_exp();
        exp_t e;
        int idx;
        idx     = m_v * t_htot + m_h;
        e.hs    = (m_run && m_h < t_hsw) ^ cur.hinv;
        e.vs    = (m_run && m_v < t_vsw) ^ cur.vinv;
        e.de    = m_run && idx >= t_dst && idx <= t_dend && m_h >= t_hst && m_h <= t_hend;
        e.dv    = e.de && (m_h < t_dve);
        e.rdy   = e.dv;
        e.px    = !e.dv ? 64'h0 : (cur.sv ? cur.sd : {cur.ucol, cur.ucol});
        e.uf    = m_uf;
        e.line  = m_v;
        e.frame = m_f;
        e.ph    = phase;
        return e;
    endfunction

    function automatic void model_update();
        exp_t e;
        if (cur.rst) begin
            m_run = 0; m_h = 0; m_v = 0; m_f = 0; m_uf = 0;
        end else if (!cur.en) begin
            m_run = 0; m_h = 0; m_v = 0; m_f = 0;
        end else if (!m_run) begin
            m_run = 1; m_h = 0; m_v = 0; m_f = 0; m_uf = 0;
            derive_m();
        end else begin
            e = calc_exp();
            if (e.dv && !cur.sv) m_uf = 1;
            if (m_h == t_htot - 1) begin
                m_h = 0;
                if (m_v == t_vtot - 1) begin
                    m_v = 0; m_f = m_f + 1;
                    derive_m();                         // R7 capture point
                end else m_v = m_v + 1;
            end else m_h = m_h + 1;
        end
    endfunction

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            model_update();
            #1;
            cyc++;
            drv.sv = (sv_mode == 0) ? 1'b1 : (sv_mode == 1) ? (cyc % 7 != 0) : 1'b0;
            drv.sd = {cyc, ~cyc};
            cur = drv;
            q.push_back(calc_exp());
        end
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp, string ph);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, ph, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk("R2", "hsync", 64'(hsync), 64'(e.hs), e.ph);
            chk("R2", "vsync", 64'(vsync), 64'(e.vs), e.ph);
            chk("R3/R4/R5", "disp_en", 64'(disp_en), 64'(e.de), e.ph);
            chk("R6", "data_valid", 64'(data_valid), 64'(e.dv), e.ph);
            chk("R9", "px_ready", 64'(px_ready), 64'(e.rdy), e.ph);
            chk("R9/R10", "px_data", px_data, e.px, e.ph);
            chk("R10", "underflow", 64'(underflow), 64'(e.uf), e.ph);
            chk("R1/R8", "line_cnt", 64'(line_cnt), 64'(e.line), e.ph);
            chk("R1/R8", "frame_cnt", 64'(frame_cnt), 64'(e.frame), e.ph);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        drv = '{rst: 1'b1, en: 1'b0, wide: 1'b0, dp: 1'b0, hinv: 1'b0, vinv: 1'b0,
                hsw: 12'd2, hbp: 12'd3, hact: 12'd8, hfp: 12'd2,
                vsw: 12'd1, vbp: 12'd2, vact: 12'd3, vfp: 12'd1, skew: 12'd0,
                ucol: 32'h00FF_10A5, sv: 1'b1, sd: 64'h0};
        cur = drv;
        // reset state
        phase = "R8 reset";
        step(3);
        drv.rst = 1'b0;
        step(2);
        // R1 R2 R3: narrow generic baseline, 15x7 raster
        phase = "R1/R2/R3";
        drv.en = 1'b1;
        step(250);
        // R4: link-style window, skew, inverted syncs, intermittent source
        drv.en = 1'b0; step(1);
        phase = "R4";
        drv.dp = 1'b1; drv.skew = 12'd3; drv.hinv = 1'b1; drv.vinv = 1'b1;
        sv_mode = 1; drv.en = 1'b1;
        step(230);
        // R5: wide link-style, horizontal halving
        drv.en = 1'b0; step(1);
        phase = "R5";
        drv.wide = 1'b1; drv.hinv = 1'b0; drv.vinv = 1'b0; drv.skew = 12'd0;
        drv.hsw = 12'd4; drv.hbp = 12'd6; drv.hact = 12'd16; drv.hfp = 12'd4;
        sv_mode = 0; drv.en = 1'b1;
        step(230);
        // R6: wide generic, full line but half data window
        drv.en = 1'b0; step(1);
        phase = "R6";
        drv.dp = 1'b0;
        drv.en = 1'b1;
        step(440);
        // R7: settings changed mid-frame take effect at the frame boundary
        phase = "R7";
        step(50);
        drv.wide = 1'b0; drv.hact = 12'd6; drv.vact = 12'd2; drv.skew = 12'd2;
        step(400);
        // R8: drop enable mid-frame, then restart
        phase = "R8";
        drv.en = 1'b0; step(3);
        drv.en = 1'b1; step(60);
        // R10: source starves, flag stays until restart
        phase = "R10";
        sv_mode = 2; step(100);
        sv_mode = 0; step(60);
        drv.en = 1'b0; step(1);
        drv.en = 1'b1; step(40);
        @(negedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule